// File: doc/BRIEF.md
# Four-Level Strap Configuration Decoder

This block turns a set of multi-level configuration straps and three plain configuration pins into a management address and a word of default configuration bits for a dual-speed Ethernet transceiver. A front end that this block does not contain senses each strap and reports its level as a 2-bit code. From that code the block takes two independent bits. One is an address bit, which tells the upper pair of levels from the lower pair. The other is a function bit, which tells the two middle levels from the two extreme ones. The function bits of straps 0 to 3 select negotiation enable, repeater mode, symbol mode and scrambler bypass. Strap 4 works together with the plain pins: it picks the fibre or copper medium when negotiation is off, and it shapes the advertised abilities when negotiation is on.

A lock input chooses between two behaviours. With lock low, the decoded values are captured once, as soon as reset has finished and the pin synchronizer is primed. After that, a management write can replace the configuration word. With lock high, the pins drive the outputs continuously and management writes are dropped. When negotiation is enabled, a synchronized rising edge on the speed pin produces a one-cycle negotiation restart pulse. Edges are not recognised while reset is active or while the synchronizer is still priming.

Top module: `strap_cfg_decoder`

## Requirements
- R1: Strap i (bits 2i+1:2i of `strap_lvl_i`) uses the code 2'b11 for the highest level, 2'b10 for the upper middle, 2'b01 for the lower middle and 2'b00 for the lowest. `phy_addr_o[i]` is 1 exactly for the codes 2'b11 and 2'b10.
- R2: The function bit of a strap is 1 for 2'b10 and 2'b01 and 0 for 2'b11 and 2'b00. The function bits of straps 0, 1, 2 and 3 appear in `cfg_o` bits 0 (negotiation enable), 1 (repeater), 2 (symbol mode) and 3 (scrambler bypass).
- R3: With negotiation off, `cfg_o` bit 4 (fibre select) is the strap 4 function bit, bit 5 (100 Mb/s) is the synchronized `cfg0_i`, bit 6 (full duplex) is `fde_i` and bit 7 (link test off) is `cfg1_i`. With negotiation on, these four bits read 0.
- R4: Advertisement occupies `cfg_o` bits 8 (10 half), 9 (10 full), 10 (100 half) and 11 (100 full). When the strap 4 function bit is 0 and `cfg1_i` is low, all four are 1 and `fde_i` has no effect.
- R5: When the strap 4 function bit is 0 and `cfg1_i` is high, only the 10 Mb/s abilities are advertised: 10 half is 1 and 10 full follows `fde_i`.
- R6: When the strap 4 function bit is 1 and `cfg1_i` is low, only the 100 Mb/s abilities are advertised: 100 half is 1 and 100 full follows `fde_i`.
- R7: When the strap 4 function bit is 1 and `cfg1_i` is high, both half-duplex bits are 1 and both full-duplex bits follow `fde_i`.
- R8: With `mgmt_lock_i` low, the address and the configuration are captured once after reset. Later changes on the pins leave both outputs unchanged.
- R9: With `mgmt_lock_i` low, a cycle with `wr_en_i` high loads `wr_data_i` into `cfg_o` from the next clock edge on. The address is not affected.
- R10: With `mgmt_lock_i` high, both outputs follow the pins within a few cycles, and `wr_en_i` has no effect.
- R11: When negotiation is enabled, each rising edge of `cfg0_i` gives exactly one single-cycle `an_restart_o` pulse after a two-flop synchronizer. A falling edge gives none. An edge while negotiation is disabled gives none. A pin that is already high when reset is released gives none.
- R12: While `rst_n` is low, all outputs are 0. The release of `rst_n` is synchronized internally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_lvl_i | input | 2*N_STRAPS | Sensed level code per strap |
| fde_i | input | 1 | Full-duplex pin |
| cfg0_i | input | 1 | Speed / negotiation restart pin |
| cfg1_i | input | 1 | Link test / advertisement pin |
| mgmt_lock_i | input | 1 | High: pins drive continuously and writes are blocked |
| wr_en_i | input | 1 | Management write strobe |
| wr_data_i | input | 12 | Management write data for the configuration word |
| phy_addr_o | output | N_STRAPS | Management address |
| cfg_o | output | 12 | Configuration word |
| an_restart_o | output | 1 | One-cycle negotiation restart pulse |

## Verification
The bench uses the default parameters: five straps and two synchronizer stages. The five straps cover the full address range and all four strap 4 / `cfg1_i` advertisement rows. With two stages, the priming window lasts three cycles. This is short enough for the bench to release reset with `cfg0_i` already high and confirm that no restart follows. It also lets the bench follow the pulse latency through the synchronizer and the output register.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int CFG_W = 12;

  typedef struct packed {
    logic [3:0] adv;          // 11:100 full, 10:100 half, 9:10 full, 8:10 half
    logic       lnk_test_off;
    logic       duplex_full;
    logic       speed_hi;
    logic       fiber_sel;
    logic       scr_bypass;
    logic       sym_mode;
    logic       rptr_mode;
    logic       an_en;
  } cfg_t;

  // upper pair of levels gives address 1
  function automatic logic lvl_addr(input logic [1:0] code);
    return code[1];
  endfunction

  // middle levels give function 1
  function automatic logic lvl_func(input logic [1:0] code);
    return code[1] ^ code[0];
  endfunction
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/strap_level_decode.sv
module strap_level_decode import strap_cfg_pkg::*; #(
  parameter int N_STRAPS = 5
) (
  input  logic [2*N_STRAPS-1:0] lvl_i,
  output logic [N_STRAPS-1:0]   addr_o,
  output logic [N_STRAPS-1:0]   func_o
);
  for (genvar g = 0; g < N_STRAPS; g++) begin : g_strap
    assign addr_o[g] = lvl_addr(lvl_i[2*g+1 -: 2]);
    assign func_o[g] = lvl_func(lvl_i[2*g+1 -: 2]);
  end
endmodule

// File: rtl/strap_cfg_map.sv
module strap_cfg_map import strap_cfg_pkg::*; (
  input  logic [4:0] func_i,
  input  logic       fde_i,
  input  logic       cfg0_i,
  input  logic       cfg1_i,
  output cfg_t       cfg_o
);
  always_comb begin
    cfg_o            = '0;
    cfg_o.an_en      = func_i[0];
    cfg_o.rptr_mode  = func_i[1];
    cfg_o.sym_mode   = func_i[2];
    cfg_o.scr_bypass = func_i[3];
    if (!func_i[0]) begin
      cfg_o.fiber_sel    = func_i[4];
      cfg_o.speed_hi     = cfg0_i;
      cfg_o.duplex_full  = fde_i;
      cfg_o.lnk_test_off = cfg1_i;
    end
    case ({func_i[4], cfg1_i})
      2'b00:   cfg_o.adv = 4'b1111;
      2'b01:   cfg_o.adv = {2'b00, fde_i, 1'b1};
      2'b10:   cfg_o.adv = {fde_i, 1'b1, 2'b00};
      default: cfg_o.adv = {fde_i, 1'b1, fde_i, 1'b1};
    endcase
  end
endmodule

// File: rtl/strap_edge_detect.sv
module strap_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic ready_o
);
  localparam int CW = $clog2(STAGES + 2);
  localparam logic [CW-1:0] ARM_CNT = CW'(STAGES + 1);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
    cnt_d  = (cnt_q == ARM_CNT) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
      cnt_q  <= cnt_d;
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign ready_o = (cnt_q == ARM_CNT);
  assign rise_o  = ready_o & level_o & ~prev_q;

  assert_ready_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
endmodule

// File: rtl/strap_cfg_decoder.sv
module strap_cfg_decoder import strap_cfg_pkg::*; #(
  parameter int N_STRAPS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*N_STRAPS-1:0] strap_lvl_i,
  input  logic                  fde_i,
  input  logic                  cfg0_i,
  input  logic                  cfg1_i,
  input  logic                  mgmt_lock_i,
  input  logic                  wr_en_i,
  input  logic [CFG_W-1:0]      wr_data_i,
  output logic [N_STRAPS-1:0]   phy_addr_o,
  output logic [CFG_W-1:0]      cfg_o,
  output logic                  an_restart_o
);
  logic                rst_int_n;
  logic [N_STRAPS-1:0] addr_w, func_w;
  logic                cfg0_s, cfg0_rise, sync_ready;
  cfg_t                dec_cfg;

  cfg_t                cfg_q, cfg_d;
  logic [N_STRAPS-1:0] addr_q;
  logic                init_done_q, init_done_d;
  logic                restart_q, restart_d;
  logic                pin_load, cfg_en;

  strap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n));

  strap_level_decode #(.N_STRAPS(N_STRAPS)) u_lvl (
    .lvl_i(strap_lvl_i), .addr_o(addr_w), .func_o(func_w));

  strap_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .d_i(cfg0_i),
    .level_o(cfg0_s), .rise_o(cfg0_rise), .ready_o(sync_ready));

  strap_cfg_map u_map (
    .func_i(func_w[4:0]), .fde_i(fde_i), .cfg0_i(cfg0_s),
    .cfg1_i(cfg1_i), .cfg_o(dec_cfg));

  // next state
  always_comb begin
    pin_load    = sync_ready && (!init_done_q || mgmt_lock_i);
    cfg_en      = pin_load || (init_done_q && wr_en_i);
    cfg_d       = pin_load ? dec_cfg : cfg_t'(wr_data_i);
    init_done_d = init_done_q | sync_ready;
    restart_d   = cfg0_rise & cfg_q.an_en & init_done_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q       <= '0;
      addr_q      <= '0;
      init_done_q <= 1'b0;
      restart_q   <= 1'b0;
    end else begin
      if (cfg_en)   cfg_q  <= cfg_d;
      if (pin_load) addr_q <= addr_w;
      init_done_q <= init_done_d;
      restart_q   <= restart_d;
    end
  end

  assign phy_addr_o   = addr_q;
  assign cfg_o        = cfg_q;
  assign an_restart_o = restart_q;

  assert_hold_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (init_done_q && !mgmt_lock_i && !wr_en_i) |=> $stable(cfg_q));

  assert_addr_kept_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (init_done_q && !mgmt_lock_i) |=> $stable(addr_q));

  assert_half_advertised_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (init_done_q && mgmt_lock_i && $past(mgmt_lock_i) && $past(init_done_q))
      |-> (cfg_q.adv[0] | cfg_q.adv[2]));

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart_q |=> !restart_q);

  assert_pulse_needs_an_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart_q |-> $past(cfg_q.an_en));
endmodule

// File: tb/test_strap_cfg_decoder.sv
module test_strap_cfg_decoder;
  localparam int NS = 5;

  logic clk, rst_n;
  logic [2*NS-1:0] strap;
  logic fde, cfg0, cfg1, lock, wr_en;
  logic [11:0] wr_data;
  logic [NS-1:0] addr;
  logic [11:0] cfg;
  logic an_restart;

  int n_chk = 0, n_bad = 0, pulse_cnt = 0;

  typedef struct {
    string       tag;
    logic [4:0]  addr;
    logic [11:0] cfg;
    int          pulses;
  } exp_t;
  exp_t sbq[$];
  event smp_ev;

  strap_cfg_decoder i_strap_cfg_decoder (
    .clk(clk), .rst_n(rst_n), .strap_lvl_i(strap), .fde_i(fde), .cfg0_i(cfg0),
    .cfg1_i(cfg1), .mgmt_lock_i(lock), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .phy_addr_o(addr), .cfg_o(cfg), .an_restart_o(an_restart));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (an_restart === 1'b1) pulse_cnt++;

  function automatic logic fb(input logic [1:0] c);
    return (c == 2'b10) || (c == 2'b01);
  endfunction

  function automatic logic [4:0] m_addr(input logic [9:0] s);
    return {s[9], s[7], s[5], s[3], s[1]};
  endfunction

  function automatic logic [11:0] m_cfg(input logic [9:0] s, input logic f, c0, c1);
    logic [3:0] adv;
    logic [7:0] lo;
    logic an;
    an = fb(s[1:0]);
    if (!fb(s[9:8]) && !c1)     adv = 4'b1111;
    else if (!fb(s[9:8]) && c1) adv = {2'b00, f, 1'b1};
    else if (!c1)               adv = {f, 1'b1, 2'b00};
    else                        adv = {f, 1'b1, f, 1'b1};
    if (an) lo = {4'b0000, fb(s[7:6]), fb(s[5:4]), fb(s[3:2]), 1'b1};
    else    lo = {c1, f, c0, fb(s[9:8]), fb(s[7:6]), fb(s[5:4]), fb(s[3:2]), 1'b0};
    return {adv, lo};
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(smp_ev);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_chk++;
        if (addr !== e.addr) begin
          n_bad++;
          $display("FAIL %s addr: got %b expected %b", e.tag, addr, e.addr);
        end
        n_chk++;
        if (cfg !== e.cfg) begin
          n_bad++;
          $display("FAIL %s cfg: got %h expected %h", e.tag, cfg, e.cfg);
        end
        if (e.pulses >= 0) begin
          n_chk++;
          if (pulse_cnt != e.pulses) begin
            n_bad++;
            $display("FAIL %s restart pulses: got %0d expected %0d", e.tag, pulse_cnt, e.pulses);
          end
        end
        pulse_cnt = 0;
      end
    end
  end

  // driver side
  task automatic expect_now(input string tag, input logic [4:0] a, input logic [11:0] c, input int p);
    exp_t e;
    @(negedge clk); #1;
    e.tag = tag; e.addr = a; e.cfg = c; e.pulses = p;
    sbq.push_back(e);
    ->smp_ev;
  endtask

  task automatic expect_pins(input string tag, input int p);
    expect_now(tag, m_addr(strap), m_cfg(strap, fde, cfg0, cfg1), p);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mgmt_write(input logic [11:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_pins(input logic [9:0] s, input logic f, c0, c1);
    @(negedge clk);
    strap = s; fde = f; cfg0 = c0; cfg1 = c1;
  endtask

  initial begin
    logic [11:0] latched;
    logic [4:0]  lat_addr;
    rst_n = 1'b0; lock = 1'b0; wr_en = 1'b0; wr_data = '0;
    // s4=10 s3=00 s2=01 s1=10 s0=11 : negotiation off
    strap = 10'b10_00_01_10_11; fde = 1'b1; cfg0 = 1'b1; cfg1 = 1'b0;
    wait_cyc(4);
    expect_now("R12 reset outputs", 5'b0, 12'h000, 0);

    rst_n = 1'b1;
    wait_cyc(8);
    latched  = m_cfg(strap, fde, cfg0, cfg1);
    lat_addr = m_addr(strap);
    expect_pins("R1 R2 R3 R8 capture", -1);

    set_pins(10'b01_11_00_01_00, 1'b0, 1'b0, 1'b1);
    wait_cyc(6);
    expect_now("R8 pins ignored after capture", lat_addr, latched, 0);

    mgmt_write(12'hA5C);
    wait_cyc(1);
    expect_now("R9 write loads cfg", lat_addr, 12'hA5C, 0);

    // lock high, negotiation on
    lock = 1'b1;
    set_pins(10'b00_01_11_00_10, 1'b0, 1'b0, 1'b0);
    wait_cyc(6);
    expect_pins("R10 R1 R2 follow pins", 0);

    mgmt_write(12'h3F0);
    wait_cyc(2);
    expect_pins("R10 write ignored", 0);

    set_pins(10'b00_01_11_00_10, 1'b1, 1'b0, 1'b0);
    wait_cyc(5);
    expect_pins("R4 fde ignored all four", 0);
    set_pins(10'b11_00_00_11_10, 1'b0, 1'b0, 1'b1);
    wait_cyc(5);
    expect_pins("R5 10 only fde=0", 0);
    set_pins(10'b11_00_00_11_10, 1'b1, 1'b0, 1'b1);
    wait_cyc(5);
    expect_pins("R5 10 only fde=1", 0);
    set_pins(10'b01_10_00_00_01, 1'b1, 1'b0, 1'b0);
    wait_cyc(5);
    expect_pins("R6 100 only fde=1", 0);
    set_pins(10'b10_10_00_00_01, 1'b0, 1'b0, 1'b1);
    wait_cyc(5);
    expect_pins("R7 both fde=0", 0);
    set_pins(10'b10_10_00_00_01, 1'b1, 1'b0, 1'b1);
    wait_cyc(5);
    expect_pins("R7 both fde=1", 0);

    // restart edges with negotiation on
    set_pins(10'b10_10_00_00_01, 1'b1, 1'b1, 1'b1);
    wait_cyc(8);
    expect_pins("R11 rise gives one pulse", 1);
    set_pins(10'b10_10_00_00_01, 1'b1, 1'b0, 1'b1);
    wait_cyc(8);
    expect_pins("R11 fall gives none", 0);

    // negotiation off
    set_pins(10'b01_00_00_00_00, 1'b0, 1'b0, 1'b1);
    wait_cyc(6);
    expect_pins("R3 manual fields", 0);
    set_pins(10'b01_00_00_00_00, 1'b0, 1'b1, 1'b1);
    wait_cyc(8);
    expect_pins("R3 R11 speed set, no pulse", 0);

    // reset with pin already high and negotiation on
    @(negedge clk);
    rst_n = 1'b0; lock = 1'b0;
    strap = 10'b00_00_00_11_10; fde = 1'b0; cfg0 = 1'b1; cfg1 = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(12);
    expect_pins("R11 R12 high at release, no pulse", 0);

    wait_cyc(2);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got no end expected end");
    summary();
    $finish;
  end
endmodule